// File: doc/BRIEF.md
# CRC-checked SPI frame receiver

This block is the device-side serial port of a register-mapped peripheral. A host lowers an active-low select, clocks in a 32-bit word MSB first, and raises the select again. The block samples the serial clock, select and data lines with its own system clock, so the serial lines may be asynchronous to it. When the select rises, the block checks the captured word. The first bit must be the complement of the second. The two device-address bits must match the strap pins. When checking is on, the trailing CRC-8 must be correct. A word that passes becomes a one-cycle write strobe carrying a 5-bit register address and 16 data bits for the register file around the block.

Checking can be switched off through a bit in one control register. With checking off, the block also takes 24-bit words, and it takes 32-bit words without looking at their last byte. Readback takes two frames. A write to the select register names a register. During the next frame, the block shifts that register's contents out on SDO, framed with a tag, the fault state, the register address and a CRC. The serial clock may idle low or idle high, as long as the host sets up data for the falling edge.

Top module: `spi_crc_frame_rx`

## Requirements
- R1: Bits are captured MSB first on each falling edge of `sclk_i` while `sync_n_i` is low, with `sclk_i` idling either low or high. The captured word is judged when `sync_n_i` rises.
- R2: An accepted word yields `wr_en_o` high for exactly one cycle, with `wr_addr_o` = word bits 28:24 and `wr_data_o` = bits 23:8. An accepted word whose address is 0x00 (no-operation) yields no strobe.
- R3: A word whose bit 31 equals its bit 30 is dropped with no strobe and no error.
- R4: A word whose bits 30:29 differ from `dev_addr_i` is dropped with no strobe and no CRC error, even when its CRC is wrong.
- R5: With checking on, bits 7:0 must equal the CRC-8 of bits 31:8. That CRC uses polynomial x^8+x^2+x+1 (0x07), initial value zero, MSB first. On a mismatch the word is dropped, `crc_err_o` pulses for one cycle, and `fault_o` goes high and stays high until reset.
- R6: With checking on, only 32-bit words are judged. With checking off, 24-bit words are accepted, and 32-bit words are accepted with bits 7:0 ignored. Any other bit count is dropped with no strobe and no error.
- R7: An accepted write to register 0x13 sets `rd_addr_o` to data bits 4:0. During the next frame, SDO carries {2'b10, `fault_o`, `rd_addr_o`, `rd_data_i`, CRC-8 of the first 24 bits}, where `rd_data_i` is sampled when `sync_n_i` falls. In later frames SDO carries zeros.
- R8: SDO shows bit 31 of the response from the fall of `sync_n_i`. It moves to the next bit on each `sclk_i` rising edge that follows a falling edge of the frame. The response therefore reads correctly at the falling edges with either clock idle level.
- R9: Checking is on after reset. An accepted write to register 0x10 sets it to data bit 0.
- R10: After reset, `wr_en_o`, `crc_err_o`, `fault_o`, `sdo_o` and `rd_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 2 | Strap value the word's device bits must match |
| sclk_i | input | 1 | Serial clock from host |
| sync_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial readback data to host |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 5 | Register address of the write |
| wr_data_o | output | 16 | Data of the write |
| rd_addr_o | output | 5 | Register selected for readback |
| rd_data_i | input | 16 | Contents of the selected register |
| crc_err_o | output | 1 | One-cycle pulse on a CRC mismatch |
| fault_o | output | 1 | Sticky fault indication |

## Verification
The hardest states to reach are those that depend on the CRC switch. One is accepting a word with a wrong trailing byte. The other is accepting a 24-bit word. Both need a checked write to register 0x10 first. Re-enabling the check then uses a deliberately corrupted word that must still land. The two-frame readback is run in both clock idle levels, and once after a CRC fault, so that the fault bit in the response header is seen set.

// File: rtl/spi_frx_pkg.sv
package spi_frx_pkg;
   localparam int DEV_W   = 2;
   localparam int REG_W   = 5;
   localparam int DATA_W  = 16;
   localparam int CRC_W   = 8;
   localparam int HDR_W   = 1 + DEV_W + REG_W;
   localparam int BODY_W  = HDR_W + DATA_W;
   localparam int FRAME_W = BODY_W + CRC_W;
   localparam int CNT_W   = $clog2(FRAME_W) + 1;
   localparam logic [1:0] RSP_TAG = 2'b10;

   typedef struct packed {
      logic              slip;
      logic [DEV_W-1:0]  dev;
      logic [REG_W-1:0]  regad;
      logic [DATA_W-1:0] data;
      logic [CRC_W-1:0]  crc;
   } frame_t;
endpackage

// File: rtl/spi_sync_vec.sv
module spi_sync_vec #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_crc8.sv
module spi_crc8 #(
   parameter int               IN_W  = 24,
   parameter int               CRC_W = 8,
   parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
   input  logic [IN_W-1:0]  data_i,
   output logic [CRC_W-1:0] crc_o
);
   logic [CRC_W-1:0] chain [IN_W+1];

   assign chain[0] = '0;

   for (genvar i = 0; i < IN_W; i++) begin : g_bit
      logic fb;
      assign fb = chain[i][CRC_W-1] ^ data_i[IN_W-1-i];
      assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_o = chain[IN_W];
endmodule

// File: rtl/spi_shift_in.sv
module spi_shift_in #(
   parameter int W     = 32,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             sample_i,
   input  logic             bit_i,
   output logic [W-1:0]     sr_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_o  <= '0;
         cnt_o <= '0;
      end else if (start_i) begin
         cnt_o <= '0;
      end else if (sample_i) begin
         sr_o <= {sr_o[W-2:0], bit_i};
         if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/spi_crc_frame_rx.sv
module spi_crc_frame_rx
   import spi_frx_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
   parameter logic [REG_W-1:0] NOP_ADDR    = 5'h00,
   parameter logic [REG_W-1:0] CTRL_ADDR   = 5'h10,
   parameter logic [REG_W-1:0] RDSEL_ADDR  = 5'h13,
   parameter int               CRC_EN_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEV_W-1:0]  dev_addr_i,
   input  logic              sclk_i,
   input  logic              sync_n_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              wr_en_o,
   output logic [REG_W-1:0]  wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [REG_W-1:0]  rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              crc_err_o,
   output logic              fault_o
);
   localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(BODY_W);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("CRC_POLY must have its x^0 term set");
   end
   if (CTRL_ADDR == NOP_ADDR || RDSEL_ADDR == NOP_ADDR || CTRL_ADDR == RDSEL_ADDR) begin : g_bad_map
      $error("register addresses must be distinct");
   end
   if (CRC_EN_BIT < 0 || CRC_EN_BIT >= DATA_W) begin : g_bad_bit
      $error("CRC_EN_BIT out of range");
   end
   if (2 + 1 + REG_W + DATA_W != BODY_W) begin : g_bad_rsp
      $error("response body width mismatch");
   end

   // synchronised serial lines: {select, clock, data}
   logic [2:0] line_q;
   logic       cs_lvl, ck_lvl, dat_lvl;
   logic       cs_rise, cs_fall, ck_rise, ck_fall;

   spi_sync_vec #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({sync_n_i, sclk_i, sdi_i}), .q_o(line_q));

   assign {cs_lvl, ck_lvl, dat_lvl} = line_q;

   spi_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));
   spi_edge_det #(.RST_VAL(1'b0)) u_ck_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(ck_lvl), .rise_o(ck_rise), .fall_o(ck_fall));

   // capture
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   cnt;

   spi_shift_in #(.W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start_i(cs_fall),
      .sample_i(ck_fall & ~cs_lvl), .bit_i(dat_lvl),
      .sr_o(sr), .cnt_o(cnt));

   // judgement
   frame_t     frm;
   logic       len_full, len_short, hdr_ok, crc_ok;
   logic       accept, crc_bad;
   logic [CRC_W-1:0] rx_crc;

   assign len_full  = (cnt == LEN_FULL);
   assign len_short = (cnt == LEN_SHORT);

   always_comb begin
      if (len_short) frm = frame_t'({sr[BODY_W-1:0], {CRC_W{1'b0}}});
      else           frm = frame_t'(sr);
   end

   spi_crc8 #(.IN_W(BODY_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc_rx (
      .data_i(frm[FRAME_W-1:CRC_W]), .crc_o(rx_crc));

   logic crc_en_q, fault_q;

   assign hdr_ok = (frm.slip != frm.dev[DEV_W-1]) && (frm.dev == dev_addr_i);
   assign crc_ok = (rx_crc == frm.crc);

   always_comb begin
      if (crc_en_q) begin
         accept  = cs_rise & len_full & hdr_ok & crc_ok;
         crc_bad = cs_rise & len_full & hdr_ok & ~crc_ok;
      end else begin
         accept  = cs_rise & (len_full | len_short) & hdr_ok;
         crc_bad = 1'b0;
      end
   end

   // readback response
   logic [REG_W-1:0]  rd_sel_q;
   logic [BODY_W-1:0] rsp_body;
   logic [CRC_W-1:0]  rsp_crc;

   assign rsp_body = {RSP_TAG, fault_q, rd_sel_q, rd_data_i};

   spi_crc8 #(.IN_W(BODY_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc_tx (
      .data_i(rsp_body), .crc_o(rsp_crc));

   // state
   logic               wr_en_q, crc_err_q, armed_q;
   logic [REG_W-1:0]   wr_addr_q;
   logic [DATA_W-1:0]  wr_data_q;
   logic [FRAME_W-1:0] out_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         crc_err_q <= 1'b0;
         fault_q   <= 1'b0;
         crc_en_q  <= 1'b1;
         rd_sel_q  <= '0;
         armed_q   <= 1'b0;
         out_sr    <= '0;
      end else begin
         wr_en_q   <= accept && (frm.regad != NOP_ADDR);
         crc_err_q <= crc_bad;
         if (crc_bad) fault_q <= 1'b1;
         if (accept && (frm.regad != NOP_ADDR)) begin
            wr_addr_q <= frm.regad;
            wr_data_q <= frm.data;
         end
         if (accept && (frm.regad == CTRL_ADDR)) crc_en_q <= frm.data[CRC_EN_BIT];
         if (accept && (frm.regad == RDSEL_ADDR)) rd_sel_q <= frm.data[REG_W-1:0];
         if (cs_rise) armed_q <= accept && (frm.regad == RDSEL_ADDR);

         if (cs_fall)
            out_sr <= armed_q ? {rsp_body, rsp_crc} : '0;
         else if (cs_rise)
            out_sr <= '0;
         else if (ck_rise && !cs_lvl && (cnt != '0))
            out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
      end
   end

   assign sdo_o     = out_sr[FRAME_W-1];
   assign wr_en_o   = wr_en_q;
   assign wr_addr_o = wr_addr_q;
   assign wr_data_o = wr_data_q;
   assign rd_addr_o = rd_sel_q;
   assign crc_err_o = crc_err_q;
   assign fault_o   = fault_q;
endmodule

// File: rtl/spi_crc_frame_rx_chk.sv
module spi_crc_frame_rx_chk #(
   parameter logic [4:0] RDSEL_ADDR = 5'h13
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en_o,
   input logic [4:0] wr_addr_o,
   input logic [4:0] rd_addr_o,
   input logic       crc_err_o,
   input logic       fault_o,
   input logic       sdo_o,
   input logic       ck_rise,
   input logic       cs_rise,
   input logic       cs_fall
);
   p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   p_no_nop_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_addr_o != 5'h00));

   p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && crc_err_o));

   p_err_sets_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err_o |-> fault_o);

   p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> fault_o);

   p_sel_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_addr_o) |-> (wr_en_o && (wr_addr_o == RDSEL_ADDR)));

   p_sdo_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ck_rise || cs_rise || cs_fall) |=> $stable(sdo_o));
endmodule

bind spi_crc_frame_rx spi_crc_frame_rx_chk #(.RDSEL_ADDR(RDSEL_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
   .rd_addr_o(rd_addr_o), .crc_err_o(crc_err_o), .fault_o(fault_o),
   .sdo_o(sdo_o), .ck_rise(ck_rise), .cs_rise(cs_rise), .cs_fall(cs_fall));

// File: tb/spi_crc_frame_rx_bench.sv
module spi_crc_frame_rx_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  dev_addr_i = 2'b01;
   logic        sclk_i = 1'b0;
   logic        sync_n_i = 1'b1;
   logic        sdi_i = 1'b0;
   logic        sdo_o, wr_en_o, crc_err_o, fault_o;
   logic [4:0]  wr_addr_o, rd_addr_o;
   logic [15:0] wr_data_o, rd_data_i;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int err_cnt = 0;
   logic [4:0]  last_addr = '0;
   logic [15:0] last_data = '0;
   bit fault_exp = 1'b0;

   always #10 clk = ~clk;

   spi_crc_frame_rx u_spi_crc_frame_rx (
      .clk(clk), .rst_n(rst_n), .dev_addr_i(dev_addr_i), .sclk_i(sclk_i),
      .sync_n_i(sync_n_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .wr_en_o(wr_en_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .rd_addr_o(rd_addr_o),
      .rd_data_i(rd_data_i), .crc_err_o(crc_err_o), .fault_o(fault_o));

   function automatic logic [15:0] reg_model(input logic [4:0] a);
      return {3'b101, a, 8'h3C};
   endfunction

   assign rd_data_i = reg_model(rd_addr_o);

   always @(negedge clk) begin
      if (wr_en_o) begin
         wr_cnt++;
         last_addr = wr_addr_o;
         last_data = wr_data_o;
      end
      if (crc_err_o) err_cnt++;
   end

   // bytewise reference CRC-8, polynomial 0x07, zero start
   function automatic logic [7:0] ref_crc(input logic [23:0] body);
      logic [7:0] c = 8'h00;
      for (int b = 2; b >= 0; b--) begin
         c = c ^ body[b*8 +: 8];
         for (int k = 0; k < 8; k++)
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [31:0] mk(input logic [1:0] dev, input logic [4:0] a,
                                      input logic [15:0] d, input bit bad_crc);
      logic [23:0] body = {~dev[1], dev, a, d};
      return {body, ref_crc(body) ^ (bad_crc ? 8'h5A : 8'h00)};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic [31:0] tx, input int nbits, input bit idle_hi,
                       output logic [31:0] rx);
      rx = '0;
      sclk_i = idle_hi;
      repeat (10) @(negedge clk);
      sync_n_i = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         if (!idle_hi) begin
            repeat (4) @(negedge clk);
            sdi_i = tx[i];
            repeat (4) @(negedge clk);
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            rx = {rx[30:0], sdo_o};
            sclk_i = 1'b0;
         end else begin
            sdi_i = tx[i];
            repeat (8) @(negedge clk);
            rx = {rx[30:0], sdo_o};
            sclk_i = 1'b0;
            repeat (8) @(negedge clk);
            sclk_i = 1'b1;
         end
      end
      repeat (8) @(negedge clk);
      sync_n_i = 1'b1;
      repeat (16) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] tx, input int nbits, input bit idle_hi);
      logic [31:0] dummy;
      xfer(tx, nbits, idle_hi, dummy);
   endtask

   task automatic t_reset;
      check("R10", "wr_en", {31'd0, wr_en_o}, 32'd0);
      check("R10", "crc_err", {31'd0, crc_err_o}, 32'd0);
      check("R10", "fault", {31'd0, fault_o}, 32'd0);
      check("R10", "sdo", {31'd0, sdo_o}, 32'd0);
      check("R10", "rd_addr", {27'd0, rd_addr_o}, 32'd0);
   endtask

   task automatic t_write(input bit idle_hi, input logic [4:0] a, input logic [15:0] d);
      int w0 = wr_cnt;
      send(mk(2'b01, a, d, 1'b0), 32, idle_hi);
      check("R1", "strobe count", wr_cnt - w0, 1);
      check("R2", "write addr", {27'd0, last_addr}, {27'd0, a});
      check("R2", "write data", {16'd0, last_data}, {16'd0, d});
   endtask

   task automatic t_slip_bad;
      int w0 = wr_cnt, e0 = err_cnt;
      logic [23:0] body = {1'b0, 2'b01, 5'h09, 16'h1111};
      send({body, ref_crc(body)}, 32, 1'b0);
      check("R3", "slip strobe", wr_cnt - w0, 0);
      check("R3", "slip err", err_cnt - e0, 0);
   endtask

   task automatic t_dev_mismatch;
      int w0 = wr_cnt, e0 = err_cnt;
      send(mk(2'b10, 5'h09, 16'h2222, 1'b0), 32, 1'b0);
      check("R4", "other device strobe", wr_cnt - w0, 0);
      send(mk(2'b10, 5'h09, 16'h2222, 1'b1), 32, 1'b0);
      check("R4", "other device bad crc err", err_cnt - e0, 0);
      check("R4", "fault after mismatch", {31'd0, fault_o}, {31'd0, fault_exp});
   endtask

   task automatic t_nop;
      int w0 = wr_cnt;
      send(mk(2'b01, 5'h00, 16'h0000, 1'b0), 32, 1'b0);
      check("R2", "nop strobe", wr_cnt - w0, 0);
   endtask

   task automatic t_length_on;
      int w0 = wr_cnt, e0 = err_cnt;
      logic [31:0] f = mk(2'b01, 5'h0C, 16'h3333, 1'b0);
      send(f >> 1, 31, 1'b0);
      check("R6", "31-bit strobe", wr_cnt - w0, 0);
      send(f >> 8, 24, 1'b0);
      check("R6", "24-bit with crc on strobe", wr_cnt - w0, 0);
      check("R6", "length err", err_cnt - e0, 0);
   endtask

   task automatic t_readback(input bit idle_hi, input logic [4:0] sel);
      logic [31:0] rx;
      logic [23:0] body;
      int w0;
      send(mk(2'b01, 5'h13, {11'd0, sel}, 1'b0), 32, idle_hi);
      check("R7", "rd_addr", {27'd0, rd_addr_o}, {27'd0, sel});
      w0 = wr_cnt;
      xfer(mk(2'b01, 5'h00, 16'h0000, 1'b0), 32, idle_hi, rx);
      body = {2'b10, fault_exp, sel, reg_model(sel)};
      check(idle_hi ? "R8" : "R7", "response", rx, {body, ref_crc(body)});
      check("R2", "nop strobe in readback", wr_cnt - w0, 0);
      xfer(mk(2'b01, 5'h00, 16'h0000, 1'b0), 32, idle_hi, rx);
      check("R7", "second frame zeros", rx, 32'd0);
   endtask

   task automatic t_bad_crc;
      int w0 = wr_cnt, e0 = err_cnt;
      send(mk(2'b01, 5'h0D, 16'h4444, 1'b1), 32, 1'b0);
      fault_exp = 1'b1;
      check("R5", "bad crc strobe", wr_cnt - w0, 0);
      check("R5", "crc_err pulses", err_cnt - e0, 1);
      check("R5", "fault set", {31'd0, fault_o}, 32'd1);
      t_write(1'b0, 5'h0E, 16'h5555);
      check("R5", "fault held", {31'd0, fault_o}, 32'd1);
   endtask

   task automatic t_crc_switch;
      int w0, e0;
      t_write(1'b0, 5'h10, 16'h0000);
      w0 = wr_cnt;
      send({8'd0, ~1'b0, 2'b01, 5'h0B, 16'hBEEF}, 24, 1'b0);
      check("R9", "24-bit accepted when off", wr_cnt - w0, 1);
      check("R6", "24-bit data", {16'd0, last_data}, 32'h0000BEEF);
      send(mk(2'b01, 5'h0A, 16'hCAFE, 1'b1), 32, 1'b1);
      check("R6", "32-bit crc ignored", wr_cnt - w0, 2);
      check("R6", "32-bit data", {16'd0, last_data}, 32'h0000CAFE);
      e0 = err_cnt;
      send(mk(2'b01, 5'h10, 16'h0001, 1'b1), 32, 1'b0);
      check("R9", "enable write taken", wr_cnt - w0, 3);
      send(mk(2'b01, 5'h0A, 16'h7777, 1'b1), 32, 1'b0);
      check("R9", "check back on strobe", wr_cnt - w0, 3);
      check("R9", "check back on err", err_cnt - e0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write(1'b0, 5'h08, 16'h15FA);
      t_write(1'b1, 5'h0A, 16'h1234);
      t_slip_bad();
      t_dev_mismatch();
      t_nop();
      t_length_on();
      t_readback(1'b0, 5'h05);
      t_bad_crc();
      t_readback(1'b1, 5'h14);
      t_crc_switch();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule